// File: doc/BRIEF.md
# Pipelined SPI ADC Scan Sequencer

This block is an SPI master that sweeps the inputs of a multi-channel successive-approximation converter. The converter returns each result two frames after the command that asked for it. A start pulse launches a pass over the channels set in an enable mask. The block sends one 16-bit command per enabled channel, lowest index first. It then sends two padding frames so that every conversion is clocked back. Each word that comes back is paired with the command issued two frames earlier. The block compares the word's channel tag against that command and unpacks the sample. It then offers the channel, the sample and an error flag on a valid/ready output.

A second mode reads one channel in isolation. The same command is sent in the first two frames, and only the word received in the third frame is kept. The serial clock is a fixed division of the system clock. Between frames the chip select is held high for a minimum time.

Top module: `adc_scan_seq`

## Requirements
- R1: Every command frame is 16 bits, shifted MSB first. Bit 12 (manual channel select), bit 11 (settings write) and bit 6 (double input range) are set, bits 10:7 hold the channel number, and all other bits are zero.
- R2: A scan with K enabled channels sends exactly K+2 frames. The commands go out in ascending channel order, and the two final frames carry all-zero data.
- R3: The word received in frame i+2 becomes result i, and the words of the first two frames are discarded. Each result reports on `res_chan_o` the channel commanded for that slot, and results leave in command order.
- R4: `res_err_o` is 1 exactly when bits 15:12 of the received word differ from the commanded channel.
- R5: For resolution R (`RES_BITS`, 8 to 12), `res_data_o` equals received bits [11:12-R].
- R6: In single mode, frames 1 and 2 both carry the command for `single_ch_i` and frame 3 carries zero. The scan yields exactly one result, taken from frame 3.
- R7: SCLK idles low whenever chip select is high. MOSI changes only on falling SCLK edges, and MISO is sampled on rising edges. Chip select is high for at least 2 system clocks between frames, and it stays high after the last frame.
- R8: A start pulse that arrives while `busy_o` is high has no effect on the running scan and produces no extra frames, results or done pulse.
- R9: `done_o` pulses for one cycle once the last frame of a scan has completed. A start with an all-zero mask (not in single mode) raises `done_o` on the next cycle and sends no frame.
- R10: A result is held stable while `res_ready_i` is low. The scan stalls rather than lose a result, so every slot is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| single_i | input | 1 | Selects single-channel read mode at start |
| single_ch_i | input | 4 | Channel for single-channel read |
| chan_mask_i | input | NUM_CH | Channel enable mask, captured at start |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle end-of-scan pulse |
| spi_sclk_o | output | 1 | Serial clock, idles low |
| spi_cs_n_o | output | 1 | Active-low chip select |
| spi_mosi_o | output | 1 | Serial data to converter |
| spi_miso_i | input | 1 | Serial data from converter |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Consumer accepts result |
| res_chan_o | output | 4 | Channel commanded for this result |
| res_data_o | output | RES_BITS | Extracted sample |
| res_err_o | output | 1 | Channel tag mismatch |

## Verification
The hardest case to reach is a wrong tag or a lost result in the very last slot, because that word arrives in the second padding frame. A short-lived slip in the two-frame realignment would go unseen if only early slots were checked. The bench's converter model keeps its own two-deep response pipeline, so it can corrupt the tag of any chosen channel. Full masks are run with the corrupted channel placed at the first and the last slot. Some of those runs also drop `res_ready_i` pseudo-randomly, so that the output stall coincides with the padding frames.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  localparam int FRAME_W      = 16;
  localparam int TAG_W        = 4;
  localparam int BIT_MANUAL   = 12;
  localparam int BIT_WR_EN    = 11;
  localparam int CH_LSB       = 7;
  localparam int BIT_RANGE_2X = 6;

  typedef struct packed {
    logic             vld;
    logic [TAG_W-1:0] ch;
  } slot_t;

  function automatic logic [FRAME_W-1:0] make_cmd(input logic [TAG_W-1:0] ch);
    logic [FRAME_W-1:0] w;
    w                          = '0;
    w[BIT_MANUAL]              = 1'b1;
    w[BIT_WR_EN]               = 1'b1;
    w[CH_LSB+TAG_W-1:CH_LSB]   = ch;
    w[BIT_RANGE_2X]            = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/adc_spi_frame.sv
module adc_spi_frame #(
  parameter int SCLK_HALF = 2,
  parameter int CS_GAP    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        launch_i,
  input  logic [15:0] tx_word_i,
  output logic        idle_o,
  output logic        done_o,
  output logic [15:0] rx_word_o,
  output logic        sclk_o,
  output logic        cs_n_o,
  output logic        mosi_o,
  input  logic        miso_i
);

  localparam int DIV_W = $clog2(SCLK_HALF + 1);
  localparam int GAP_W = $clog2(CS_GAP + 1);

  typedef enum logic [1:0] {F_IDLE, F_SHIFT, F_GAP} fst_t;

  fst_t             st_q, st_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [3:0]       bit_q, bit_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic [15:0]      tx_q, tx_d, rx_q, rx_d;
  logic             sclk_q, sclk_d, cs_q, cs_d, done_q, done_d;
  logic             tick;

  assign tick = (div_q == DIV_W'(SCLK_HALF - 1));

  always_comb begin
    st_d   = st_q;
    div_d  = div_q;
    bit_d  = bit_q;
    gap_d  = gap_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    sclk_d = sclk_q;
    cs_d   = cs_q;
    done_d = 1'b0;
    case (st_q)
      F_IDLE: begin
        if (launch_i) begin
          st_d   = F_SHIFT;
          cs_d   = 1'b0;
          tx_d   = tx_word_i;
          div_d  = '0;
          bit_d  = '0;
          sclk_d = 1'b0;
        end
      end
      F_SHIFT: begin
        if (tick) begin
          div_d  = '0;
          sclk_d = ~sclk_q;
          if (!sclk_q) begin
            rx_d = {rx_q[14:0], miso_i};
          end else begin
            tx_d = {tx_q[14:0], 1'b0};
            if (bit_q == 4'd15) begin
              st_d   = F_GAP;
              cs_d   = 1'b1;
              done_d = 1'b1;
              gap_d  = '0;
            end else begin
              bit_d = bit_q + 4'd1;
            end
          end
        end else begin
          div_d = div_q + DIV_W'(1);
        end
      end
      F_GAP: begin
        if (gap_q == GAP_W'(CS_GAP - 1)) st_d = F_IDLE;
        else                             gap_d = gap_q + GAP_W'(1);
      end
      default: st_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= F_IDLE;
      div_q  <= '0;
      bit_q  <= '0;
      gap_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      div_q  <= div_d;
      bit_q  <= bit_d;
      gap_q  <= gap_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      sclk_q <= sclk_d;
      cs_q   <= cs_d;
      done_q <= done_d;
    end
  end

  assign idle_o    = (st_q == F_IDLE);
  assign done_o    = done_q;
  assign rx_word_o = rx_q;
  assign sclk_o    = sclk_q;
  assign cs_n_o    = cs_q;
  assign mosi_o    = (st_q == F_SHIFT) & tx_q[15];

  assert_sclk_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> !sclk_q);
  assert_cs_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_q) |-> ($past(cs_q, 1) && $past(cs_q, 2)));
  assert_mosi_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && $past(sclk_q)) |-> $stable(mosi_o));

endmodule

// File: rtl/adc_low_pick.sv
module adc_low_pick #(
  parameter int NUM_CH = 16
) (
  input  logic [NUM_CH-1:0] mask_i,
  output logic [3:0]        idx_o,
  output logic [NUM_CH-1:0] rest_o
);

  always_comb begin
    idx_o = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = 4'(i);
    end
  end

  assign rest_o = mask_i & (mask_i - NUM_CH'(1));

endmodule

// File: rtl/adc_result_unpack.sv
module adc_result_unpack #(
  parameter int RES_BITS = 12
) (
  input  logic [15:0]         word_i,
  input  logic [3:0]          exp_ch_i,
  output logic [RES_BITS-1:0] sample_o,
  output logic                tag_err_o
);

  localparam int LOW = 12 - RES_BITS;

  logic [11:0] body;

  assign body      = word_i[11:0] >> LOW;
  assign sample_o  = body[RES_BITS-1:0];
  assign tag_err_o = (word_i[15:12] != exp_ch_i);

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int RES_BITS  = 12,
  parameter int SCLK_HALF = 2,
  parameter int CS_GAP    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                single_i,
  input  logic [3:0]          single_ch_i,
  input  logic [NUM_CH-1:0]   chan_mask_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                spi_sclk_o,
  output logic                spi_cs_n_o,
  output logic                spi_mosi_o,
  input  logic                spi_miso_i,
  output logic                res_valid_o,
  input  logic                res_ready_i,
  output logic [3:0]          res_chan_o,
  output logic [RES_BITS-1:0] res_data_o,
  output logic                res_err_o
);

  localparam int CNT_W = $clog2(NUM_CH + 3);

  logic                busy_q, busy_d, single_q, single_d, done_q, done_d;
  logic [3:0]          sch_q, sch_d;
  logic [NUM_CH-1:0]   pend_q, pend_d, pend_rest;
  logic [CNT_W-1:0]    idx_q, idx_d, total_q, total_d, mask_cnt;
  slot_t               p0_q, p0_d, p1_q, p1_d, p2_q, p2_d;
  logic                ov_q, ov_d, oerr_q, oerr_d;
  logic [3:0]          och_q, och_d, pick_ch, cur_ch;
  logic [RES_BITS-1:0] odat_q, odat_d, samp;
  logic                eng_idle, fr_done, launch, is_cmd, new_vld, tag_err;
  logic [15:0]         tx_word, rx_word;

  adc_low_pick #(.NUM_CH(NUM_CH)) u_pick (
    .mask_i (pend_q),
    .idx_o  (pick_ch),
    .rest_o (pend_rest)
  );

  adc_spi_frame #(.SCLK_HALF(SCLK_HALF), .CS_GAP(CS_GAP)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch_i  (launch),
    .tx_word_i (tx_word),
    .idle_o    (eng_idle),
    .done_o    (fr_done),
    .rx_word_o (rx_word),
    .sclk_o    (spi_sclk_o),
    .cs_n_o    (spi_cs_n_o),
    .mosi_o    (spi_mosi_o),
    .miso_i    (spi_miso_i)
  );

  adc_result_unpack #(.RES_BITS(RES_BITS)) u_unpack (
    .word_i    (rx_word),
    .exp_ch_i  (p2_q.ch),
    .sample_o  (samp),
    .tag_err_o (tag_err)
  );

  always_comb begin
    mask_cnt = '0;
    for (int i = 0; i < NUM_CH; i++) mask_cnt = mask_cnt + CNT_W'(chan_mask_i[i]);
  end

  always_comb begin
    if (single_q) begin
      is_cmd  = (idx_q < CNT_W'(2));
      cur_ch  = sch_q;
      new_vld = (idx_q == '0);
    end else begin
      is_cmd  = |pend_q;
      cur_ch  = pick_ch;
      new_vld = is_cmd;
    end
    tx_word = is_cmd ? make_cmd(cur_ch) : 16'h0000;
  end

  assign launch = busy_q && eng_idle && (idx_q != total_q) && !ov_q;

  always_comb begin
    busy_d   = busy_q;
    single_d = single_q;
    sch_d    = sch_q;
    pend_d   = pend_q;
    idx_d    = idx_q;
    total_d  = total_q;
    p0_d     = p0_q;
    p1_d     = p1_q;
    p2_d     = p2_q;
    ov_d     = ov_q;
    och_d    = och_q;
    odat_d   = odat_q;
    oerr_d   = oerr_q;
    done_d   = 1'b0;
    if (!busy_q && start_i) begin
      idx_d = '0;
      p0_d  = '0;
      p1_d  = '0;
      p2_d  = '0;
      if (single_i) begin
        busy_d   = 1'b1;
        single_d = 1'b1;
        sch_d    = single_ch_i;
        total_d  = CNT_W'(3);
      end else if (|chan_mask_i) begin
        busy_d   = 1'b1;
        single_d = 1'b0;
        pend_d   = chan_mask_i;
        total_d  = mask_cnt + CNT_W'(2);
      end else begin
        done_d = 1'b1;
      end
    end
    if (launch) begin
      p2_d  = p1_q;
      p1_d  = p0_q;
      p0_d  = '{vld: new_vld, ch: cur_ch};
      idx_d = idx_q + CNT_W'(1);
      if (!single_q && is_cmd) pend_d = pend_rest;
    end
    if (ov_q && res_ready_i) ov_d = 1'b0;
    if (fr_done && p2_q.vld) begin
      ov_d   = 1'b1;
      och_d  = p2_q.ch;
      odat_d = samp;
      oerr_d = tag_err;
    end
    if (busy_q && fr_done && (idx_q == total_q)) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      single_q <= 1'b0;
      sch_q    <= '0;
      pend_q   <= '0;
      idx_q    <= '0;
      total_q  <= '0;
      p0_q     <= '0;
      p1_q     <= '0;
      p2_q     <= '0;
      ov_q     <= 1'b0;
      och_q    <= '0;
      odat_q   <= '0;
      oerr_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      busy_q   <= busy_d;
      single_q <= single_d;
      sch_q    <= sch_d;
      pend_q   <= pend_d;
      idx_q    <= idx_d;
      total_q  <= total_d;
      p0_q     <= p0_d;
      p1_q     <= p1_d;
      p2_q     <= p2_d;
      ov_q     <= ov_d;
      och_q    <= och_d;
      odat_q   <= odat_d;
      oerr_q   <= oerr_d;
      done_q   <= done_d;
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign res_valid_o = ov_q;
  assign res_chan_o  = och_q;
  assign res_data_o  = odat_q;
  assign res_err_o   = oerr_q;

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i) |=> $stable(total_q));
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_q && !res_ready_i) |=> (ov_q && $stable(och_q) && $stable(odat_q) && $stable(oerr_q)));
  assert_no_loss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_done && p2_q.vld) |-> !ov_q);

endmodule

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;

  localparam int NCH = 16;
  localparam int RB  = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, single = 1'b0;
  logic [3:0] sch = '0;
  logic [NCH-1:0] mask = '0;
  logic busy, done, sclk, cs_n, mosi, miso = 1'b0;
  logic rvalid, rready = 1'b1, rerr;
  logic [3:0] rchan;
  logic [RB-1:0] rdata;

  always #4 clk = ~clk;

  adc_scan_seq #(.NUM_CH(NCH), .RES_BITS(RB), .SCLK_HALF(1), .CS_GAP(2)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .single_i(single), .single_ch_i(sch),
    .chan_mask_i(mask), .busy_o(busy), .done_o(done), .spi_sclk_o(sclk),
    .spi_cs_n_o(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso), .res_valid_o(rvalid),
    .res_ready_i(rready), .res_chan_o(rchan), .res_data_o(rdata), .res_err_o(rerr)
  );

  int chk = 0, bad = 0, cyc = 0, seed = 0, bad_ch = 99;
  int fcnt = 0, gcnt = 0, dcnt = 0, f_at_done = 0, done_cyc = 0, hi_cnt = 0, min_gap = 99;
  bit bp_en = 1'b0, sclk_viol = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [15:0] m_cap = '0, m_out = '0, m_a = '0, m_b = '0;
  int m_bits = 0;
  logic [15:0] flog [0:31];
  logic [3:0] g_ch [0:31];
  logic [RB-1:0] g_dat [0:31];
  logic g_err [0:31];

  function automatic logic [RB-1:0] samp(input int ch);
    return RB'((ch * 53 + seed * 7 + 5) % (1 << RB));
  endfunction

  function automatic logic [15:0] resp_of(input logic [15:0] c);
    logic [3:0] ch, tag;
    if (c[12] && c[11]) begin
      ch  = c[10:7];
      tag = (int'(ch) == bad_ch) ? (ch ^ 4'h8) : ch;
      return {tag, samp(int'(ch)), 2'b11};
    end
    return 16'hF000;
  endfunction

  // converter model: two-frame result latency
  always @(negedge cs_n) begin m_out = m_b; m_bits = 0; miso = m_out[15]; end
  always @(posedge sclk) if (!cs_n) begin m_cap = {m_cap[14:0], mosi}; m_bits++; end
  always @(negedge sclk) if (!cs_n) begin m_out = m_out << 1; miso = m_out[15]; end
  always @(posedge cs_n) if (m_bits == 16) begin
    if (fcnt < 32) flog[fcnt] = m_cap;
    fcnt++;
    m_b = m_a;
    m_a = resp_of(m_cap);
    m_bits = 0;
  end

  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      if (cs_n) begin
        hi_cnt++;
        if (sclk) sclk_viol = 1'b1;
      end else begin
        if (hi_cnt > 0 && hi_cnt < min_gap) min_gap = hi_cnt;
        hi_cnt = 0;
      end
    end
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rready <= bp_en ? lfsr[0] : 1'b1;
  end

  always @(negedge clk) begin
    if (rvalid && rready) begin
      if (gcnt < 32) begin g_ch[gcnt] = rchan; g_dat[gcnt] = rdata; g_err[gcnt] = rerr; end
      gcnt++;
    end
    if (done) begin dcnt++; f_at_done = fcnt; done_cyc = cyc; end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    chk++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic run_scan(input logic [NCH-1:0] m, input bit sg, input logic [3:0] c,
                          input bit bp, input bit intrude);
    logic [3:0]  exp_ch [0:31];
    logic [15:0] exp_fr [0:31];
    int nres, nfr, start_cyc;
    seed++;
    nres = 0; nfr = 0;
    if (sg) begin
      exp_ch[0] = c; nres = 1;
      exp_fr[0] = 16'h1840 | (16'(c) << 7); exp_fr[1] = exp_fr[0]; exp_fr[2] = 16'h0; nfr = 3;
    end else if (m != '0) begin
      for (int i = 0; i < NCH; i++) if (m[i]) begin
        exp_ch[nres] = 4'(i);
        exp_fr[nres] = 16'h1840 | (16'(i) << 7);
        nres++;
      end
      exp_fr[nres] = 16'h0; exp_fr[nres+1] = 16'h0; nfr = nres + 2;
    end
    @(negedge clk);
    mask = m; single = sg; sch = c; bp_en = bp;
    fcnt = 0; gcnt = 0; dcnt = 0; f_at_done = -1;
    start_cyc = cyc;
    pulse_start();
    if (intrude) begin
      repeat (40) @(negedge clk);
      mask = ~m; single = !sg; sch = c + 4'd3;
      pulse_start();
    end
    for (int w = 0; w < 4000; w++) begin
      if (dcnt > 0 && gcnt >= nres) break;
      @(negedge clk);
    end
    bp_en = 1'b0;
    repeat (12) @(negedge clk);
    check(dcnt == 1, intrude ? "R8 one done only" : "R9 done pulse count", dcnt, 1);
    check(f_at_done == nfr, "R9 frames complete at done", f_at_done, nfr);
    check(fcnt == nfr, intrude ? "R8 frame count" : "R2 frame count", fcnt, nfr);
    if (m == '0 && !sg) check(done_cyc - start_cyc <= 2, "R9 zero mask done latency", done_cyc - start_cyc, 2);
    for (int i = 0; i < nfr && i < fcnt; i++)
      check(flog[i] == exp_fr[i], sg ? "R6 single frame word" : "R1 R2 frame word", flog[i], exp_fr[i]);
    check(gcnt == nres, sg ? "R6 result count" : "R3 R10 result count", gcnt, nres);
    for (int i = 0; i < nres && i < gcnt; i++) begin
      check(g_ch[i] == exp_ch[i], "R3 result channel", g_ch[i], exp_ch[i]);
      check(g_dat[i] == samp(int'(exp_ch[i])), "R5 sample value", g_dat[i], samp(int'(exp_ch[i])));
      check(g_err[i] == (int'(exp_ch[i]) == bad_ch), "R4 tag error flag", g_err[i], int'(exp_ch[i]) == bad_ch);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(cs_n === 1'b1 && sclk === 1'b0, "R7 reset idle bus", {cs_n, sclk}, 2);
    check(rvalid === 1'b0 && busy === 1'b0 && done === 1'b0, "R9 reset outputs", {rvalid, busy, done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int ch = 0; ch < NCH; ch++) run_scan(NCH'(1) << ch, 1'b0, 4'h0, 1'b0, 1'b0);
    bad_ch = 15; run_scan('1, 1'b0, 4'h0, 1'b0, 1'b0);
    bad_ch = 0;  run_scan('1, 1'b0, 4'h0, 1'b1, 1'b0);
    bad_ch = 4;  run_scan(16'h00F1, 1'b0, 4'h0, 1'b0, 1'b0);
    bad_ch = 99;
    run_scan('0, 1'b0, 4'h0, 1'b0, 1'b0);
    for (int k = 0; k < 24; k++) begin
      run_scan(lfsr ^ 16'(k * 4099), 1'b0, 4'h0, k[0], 1'b0);
    end
    bad_ch = 5;
    for (int ch = 0; ch < NCH; ch++) run_scan('0, 1'b1, 4'(ch), ch[1], 1'b0);
    bad_ch = 99;
    run_scan(16'h0A50, 1'b0, 4'h0, 1'b0, 1'b1);
    run_scan(16'h8181, 1'b0, 4'h0, 1'b1, 1'b1);
    run_scan('0, 1'b1, 4'h9, 1'b0, 1'b1);
    check(min_gap >= 2, "R7 chip select high time", min_gap, 2);
    check(!sclk_viol, "R7 sclk low while deselected", sclk_viol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", chk, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", chk, bad);
    $finish;
  end

endmodule